// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit sits beside the decoder of a small 8-bit processor. It works out the data address of one instruction. A one-cycle `start` pulse hands it an addressing-mode code, the two 8-bit index registers, a flag that picks the second index register, and the program-counter value of the first operand byte. The unit then walks the operand bytes, and the page-zero pointer bytes when the mode needs them, through one byte-wide read port. That port has a fixed one-cycle latency. When the address is ready the unit pulses `done` for one cycle. In that cycle it presents the 16-bit effective address (or, for immediate mode, the data byte in the low half) and the number of bytes the addressing mode adds to the instruction length.

The controller is a seven-state machine:

| State | What happens | Next state |
|-------|--------------|------------|
| IDLE | Waits for `start` and latches the inputs. | DONE for inherent, no-offset indexed and unused codes; OP1 for every other mode. |
| OP1 | Reads the operand byte at the program counter. | OP2 for the two-byte-operand modes, PTR1 for the indirect modes, TAIL for the rest. |
| OP2 | Reads the second operand byte and holds the first one. | TAIL |
| PTR1 | Reads page zero at the pointer that has just arrived. | PTR2 for long indirect, TAIL for short indirect. |
| PTR2 | Holds the pointer high byte and reads the pointer plus one, wrapped within page zero. | TAIL |
| TAIL | Issues no read. It builds the address from the last byte returned. | DONE |
| DONE | Presents the result. | IDLE |

Mode codes: 0 inherent, 1 immediate, 2 short direct, 3 long direct, 4 indexed with no offset, 5 short indexed, 6 long indexed, 7 short indirect, 8 long indirect. Codes 9 to 15 are unused.

Top module: `ea_gen`

## Requirements
- R1: While reset is asserted and after it is released, `done` and `mem_rd` are low and `ea` is 0000h.
- R2: Mode 0 and the unused codes 9 to 15 give `ea` = 0000h and `len` = 0, and issue no read.
- R3: Mode 1 reads one byte at `pc` and returns that byte in `ea[7:0]`, with `ea[15:8]` zero and `len` = 1.
- R4: Mode 2 reads one byte b and returns `ea` = {00h, b} with `len` = 1. Mode 3 reads `pc` and then `pc`+1, takes the first byte as the high byte, and returns `len` = 2.
- R5: Mode 4 issues no read and returns the selected index register zero-extended.
- R6: Mode 5 adds the operand byte to the index value as a 9-bit sum, so the carry lands in `ea[8]` (range 000h to 1FEh).
- R7: Mode 6 adds the high-first two-byte operand to the zero-extended index, modulo 2^16.
- R8: When `use_y` is set, modes 4 to 6 use `y_reg` and add 1 to `len`. In every other mode `use_y` changes neither `ea` nor `len`.
- R9: Mode 7 reads pointer byte p at `pc` and then reads address {00h, p}. The byte that comes back, call it t, gives `ea` = {00h, t} with `len` = 2. Pointer reads always fall in page zero.
- R10: Mode 8 reads p, then the high byte at {00h, p}, then the low byte at {00h, p+1 mod 256}, and returns `len` = 2.
- R11: The unit issues at most one read per cycle, and read data arrives one cycle later. `done` lasts exactly one cycle and never coincides with a read. From the start edge, `done` rises after 1 cycle for modes 0 and 4, after 3 for modes 1, 2 and 5, after 4 for modes 3, 6 and 7, and after 5 for mode 8.
- R12: A `start` that arrives outside IDLE, including during the DONE cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one address computation |
| mode | input | 4 | Addressing-mode code |
| x_reg | input | 8 | First index register |
| y_reg | input | 8 | Second index register |
| use_y | input | 1 | Select `y_reg` as the index |
| pc | input | 16 | Address of the first operand byte |
| mem_rd | output | 1 | Read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| done | output | 1 | One-cycle result strobe |
| ea | output | 16 | Effective address or immediate byte |
| len | output | 2 | Bytes added to the instruction length |

## Verification
The hardest situations to reach from the ports are the two wrap-around corners. The first is a long-indirect pointer at FFh, whose second byte must come from 00h. The second is a long-indexed sum that overflows past FFFFh. The bench reaches both by loading its memory model with a pointer byte of FFh and with a base of FFF0h. It also reaches a `start` that lands mid-operation and one held into the DONE cycle. For those it checks that the first result stands alone and that the unit goes quiet afterwards.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [3:0] {
        M_INH   = 4'd0,
        M_IMM   = 4'd1,
        M_DIR_S = 4'd2,
        M_DIR_L = 4'd3,
        M_IDX0  = 4'd4,
        M_IDX_S = 4'd5,
        M_IDX_L = 4'd6,
        M_IND_S = 4'd7,
        M_IND_L = 4'd8
    } ea_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OP1,
        S_OP2,
        S_PTR1,
        S_PTR2,
        S_TAIL,
        S_DONE
    } ea_state_e;
endpackage

// File: rtl/ea_idx_add.sv
module ea_idx_add #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] idx,
    output logic [AW-1:0] sum
);
    localparam int PAD = AW - DW;

    always_comb begin
        sum = base + {{PAD{1'b0}}, idx};
    end
endmodule

// File: rtl/ea_len.sv
module ea_len
    import ea_pkg::*;
(
    input  logic [3:0] mode_q,
    input  logic       ysel_q,
    output logic [1:0] len
);
    always_comb begin
        case (mode_q)
            M_IMM, M_DIR_S:   len = 2'd1;
            M_DIR_L:          len = 2'd2;
            M_IDX0:           len = {1'b0, ysel_q};
            M_IDX_S:          len = ysel_q ? 2'd2 : 2'd1;
            M_IDX_L:          len = ysel_q ? 2'd3 : 2'd2;
            M_IND_S, M_IND_L: len = 2'd2;
            default:          len = 2'd0;
        endcase
    end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import ea_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode_i,
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          use_y_i,
    input  logic [AW-1:0] pc_i,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] add_base,
    output logic [DW-1:0] add_idx,
    input  logic [AW-1:0] add_sum,
    output logic [3:0]    mode_q,
    output logic          ysel_q,
    output logic          done,
    output logic          busy,
    output logic          ptr_rd,
    output logic [AW-1:0] ea
);
    localparam int HW = AW - DW;
    localparam logic [HW-1:0] ZHI = '0;

    ea_state_e     state, nxt;
    ea_mode_e      mode_r;
    logic [DW-1:0] idx_q, hi_q, ptr_q, ptr_nx;
    logic [AW-1:0] pc_q, pc_nx;

    assign mode_q   = mode_r;
    assign add_idx  = idx_q;
    assign add_base = (mode_r == M_IDX_S) ? {ZHI, mem_rdata} : {hi_q, mem_rdata};
    assign ptr_nx   = ptr_q + 1'b1;
    assign pc_nx    = pc_q + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) begin
                case (mode_i)
                    M_IMM, M_DIR_S, M_DIR_L, M_IDX_S,
                    M_IDX_L, M_IND_S, M_IND_L: nxt = S_OP1;
                    default:                   nxt = S_DONE;
                endcase
            end
            S_OP1: begin
                if (mode_r == M_DIR_L || mode_r == M_IDX_L)      nxt = S_OP2;
                else if (mode_r == M_IND_S || mode_r == M_IND_L) nxt = S_PTR1;
                else                                             nxt = S_TAIL;
            end
            S_OP2:  nxt = S_TAIL;
            S_PTR1: nxt = (mode_r == M_IND_L) ? S_PTR2 : S_TAIL;
            S_PTR2: nxt = S_TAIL;
            S_TAIL: nxt = S_DONE;
            S_DONE: nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r <= M_INH;
            ysel_q <= 1'b0;
            idx_q  <= '0;
            hi_q   <= '0;
            ptr_q  <= '0;
            pc_q   <= '0;
            ea     <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    mode_r <= (mode_i <= 4'd8) ? ea_mode_e'(mode_i) : M_INH;
                    ysel_q <= use_y_i;
                    idx_q  <= use_y_i ? y_i : x_i;
                    pc_q   <= pc_i;
                    ea     <= (mode_i == M_IDX0) ? {ZHI, (use_y_i ? y_i : x_i)} : '0;
                end
                S_OP2:  hi_q  <= mem_rdata;
                S_PTR1: ptr_q <= mem_rdata;
                S_PTR2: hi_q  <= mem_rdata;
                S_TAIL: begin
                    case (mode_r)
                        M_IMM, M_DIR_S, M_IND_S: ea <= {ZHI, mem_rdata};
                        M_IDX_S, M_IDX_L:        ea <= add_sum;
                        M_DIR_L, M_IND_L:        ea <= {hi_q, mem_rdata};
                        default:                 ea <= ea;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd   = 1'b0;
        mem_addr = '0;
        done     = 1'b0;
        ptr_rd   = 1'b0;
        busy     = (state != S_IDLE);
        unique case (state)
            S_OP1:  begin mem_rd = 1'b1; mem_addr = pc_q; end
            S_OP2:  begin mem_rd = 1'b1; mem_addr = pc_nx; end
            S_PTR1: begin mem_rd = 1'b1; ptr_rd = 1'b1; mem_addr = {ZHI, mem_rdata}; end
            S_PTR2: begin mem_rd = 1'b1; ptr_rd = 1'b1; mem_addr = {ZHI, ptr_nx}; end
            S_DONE: done = 1'b1;
            S_IDLE, S_TAIL: ;
        endcase
    end
endmodule

// File: rtl/ea_gen.sv
module ea_gen #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [DW-1:0] x_reg,
    input  logic [DW-1:0] y_reg,
    input  logic          use_y,
    input  logic [AW-1:0] pc,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [1:0]    len
);
    logic [AW-1:0] add_base, add_sum;
    logic [DW-1:0] add_idx;
    logic [3:0]    mode_q;
    logic          ysel_q, busy, ptr_rd;

    ea_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode),
        .x_i(x_reg), .y_i(y_reg), .use_y_i(use_y), .pc_i(pc),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .add_base(add_base), .add_idx(add_idx), .add_sum(add_sum),
        .mode_q(mode_q), .ysel_q(ysel_q), .done(done), .busy(busy),
        .ptr_rd(ptr_rd), .ea(ea)
    );

    ea_idx_add #(.DW(DW), .AW(AW)) u_add (
        .base(add_base), .idx(add_idx), .sum(add_sum)
    );

    ea_len u_len (.mode_q(mode_q), .ysel_q(ysel_q), .len(len));
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          mem_rd,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] ea,
    input logic [1:0]    len,
    input logic [3:0]    mode_q,
    input logic          busy,
    input logic          ptr_rd
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    no_read_before_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(mem_rd));

    // R9
    zp_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rd |-> (mem_addr[AW-1:DW] == '0));

    // R2
    inherent_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 4'd0) |-> (ea == '0 && len == 2'd0));

    // R4
    short_direct_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 4'd2) |-> (ea[AW-1:DW] == '0));

    // R5
    no_offset_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 4'd4) |-> (ea[AW-1:DW] == '0));

    // R6
    short_idx_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == 4'd5) |-> (ea[AW-1:DW+1] == '0));

    // R12
    busy_start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(mode_q));
endmodule

bind ea_gen ea_gen_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .ea(ea), .len(len), .mode_q(mode_q),
    .busy(busy), .ptr_rd(ptr_rd)
);

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  x_reg = '0, y_reg = '0;
    logic        use_y = 1'b0;
    logic [15:0] pc = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        done;
    logic [15:0] ea;
    logic [1:0]  len;

    always #4 clk = ~clk;

    ea_gen dut (.*);

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] zp   [0:255];
    logic [7:0] prog [0:511];

    function automatic logic [7:0] rb(input logic [15:0] a);
        if (a[15:8] == 8'h00)      return zp[a[7:0]];
        else if (a[15:9] == 7'h60) return prog[a[8:0]];
        else                       return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= rb(mem_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_ea(input logic [3:0] m, input logic [7:0] ix,
                                           input logic [15:0] p);
        logic [7:0] b0, b1, q;
        b0 = rb(p);
        b1 = rb(p + 16'd1);
        q  = b0 + 8'd1;
        case (m)
            4'd1, 4'd2: return {8'h00, b0};
            4'd3:       return {b0, b1};
            4'd4:       return {8'h00, ix};
            4'd5:       return {8'h00, b0} + {8'h00, ix};
            4'd6:       return {b0, b1} + {8'h00, ix};
            4'd7:       return {8'h00, rb({8'h00, b0})};
            4'd8:       return {rb({8'h00, b0}), rb({8'h00, q})};
            default:    return 16'h0000;
        endcase
    endfunction

    function automatic int ref_len(input logic [3:0] m, input logic ys);
        case (m)
            4'd1, 4'd2: return 1;
            4'd3:       return 2;
            4'd4:       return ys ? 1 : 0;
            4'd5:       return ys ? 2 : 1;
            4'd6:       return ys ? 3 : 2;
            4'd7, 4'd8: return 2;
            default:    return 0;
        endcase
    endfunction

    function automatic int ref_lat(input logic [3:0] m);
        case (m)
            4'd1, 4'd2, 4'd5: return 3;
            4'd3, 4'd6, 4'd7: return 4;
            4'd8:             return 5;
            default:          return 1;
        endcase
    endfunction

    function automatic int ref_rds(input logic [3:0] m);
        case (m)
            4'd1, 4'd2, 4'd5:       return 1;
            4'd3, 4'd6, 4'd7:       return 2;
            4'd8:                   return 3;
            default:                return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m, input logic ys);
        if (ys) return "R8";
        case (m)
            4'd1:       return "R3";
            4'd2, 4'd3: return "R4";
            4'd4:       return "R5";
            4'd5:       return "R6";
            4'd6:       return "R7";
            4'd7:       return "R9";
            4'd8:       return "R10";
            default:    return "R2";
        endcase
    endfunction

    // mode, x, y, use_y, pc
    localparam logic [36:0] VEC [0:12] = '{
        {4'd0, 8'h11, 8'h22, 1'b0, 16'hC000},
        {4'd1, 8'h00, 8'h00, 1'b0, 16'hC001},
        {4'd2, 8'h00, 8'h00, 1'b0, 16'hC002},
        {4'd3, 8'h00, 8'h00, 1'b0, 16'hC004},
        {4'd4, 8'h3C, 8'h77, 1'b0, 16'hC006},
        {4'd4, 8'h3C, 8'hA5, 1'b1, 16'hC006},
        {4'd5, 8'h10, 8'h99, 1'b0, 16'hC008},
        {4'd5, 8'h01, 8'hF0, 1'b1, 16'hC009},
        {4'd6, 8'h80, 8'h00, 1'b0, 16'hC00A},
        {4'd7, 8'h00, 8'h00, 1'b0, 16'hC00C},
        {4'd8, 8'h00, 8'h00, 1'b0, 16'hC00D},
        {4'd2, 8'h44, 8'h55, 1'b1, 16'hC00E},
        {4'd6, 8'h01, 8'h33, 1'b1, 16'hC010}
    };

    task automatic run(input logic [3:0] m, input logic [7:0] xv, input logic [7:0] yv,
                       input logic ys, input logic [15:0] p, input string req);
        int lat, rds;
        logic [15:0] exp_ea;
        exp_ea = ref_ea(m, ys ? yv : xv, p);
        @(negedge clk);
        mode = m; x_reg = xv; y_reg = yv; use_y = ys; pc = p; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1; rds = 0;
        while (!done && lat < 20) begin
            if (mem_rd) rds++;
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1, req, "done seen", {15'd0, done}, 16'd1);
        chk(ea == exp_ea, req, "ea", ea, exp_ea);
        chk(len == 2'(ref_len(m, ys)), req, "len", {14'd0, len}, 16'(ref_len(m, ys)));
        chk(lat == ref_lat(m), "R11", "latency", 16'(lat), 16'(ref_lat(m)));
        chk(rds == ref_rds(m), "R11", "read count", 16'(rds), 16'(ref_rds(m)));
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R11", "done one cycle", {15'd0, done}, 16'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) zp[i] = 8'(i * 3 + 1);
        for (int i = 0; i < 512; i++) prog[i] = 8'(i * 37 + 11);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(done == 1'b0, "R1", "done in reset", {15'd0, done}, 16'd0);
        chk(mem_rd == 1'b0, "R1", "mem_rd in reset", {15'd0, mem_rd}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ea == 16'h0000, "R1", "ea after reset", ea, 16'h0000);
        chk(mem_rd == 1'b0 && done == 1'b0, "R1", "quiet after reset",
            {14'd0, mem_rd, done}, 16'd0);

        for (int i = 0; i < 13; i++)
            run(VEC[i][36:33], VEC[i][32:25], VEC[i][24:17], VEC[i][16], VEC[i][15:0],
                req_of(VEC[i][36:33], VEC[i][16]));

        // R6 carry into bit 8 and maximum sum
        prog[9'h100] = 8'h30;
        run(4'd5, 8'hF0, 8'h00, 1'b0, 16'hC100, "R6");
        chk(ea == 16'h0120, "R6", "carry into bit 8", ea, 16'h0120);
        prog[9'h101] = 8'hFF;
        run(4'd5, 8'hFF, 8'h00, 1'b0, 16'hC101, "R6");
        chk(ea == 16'h01FE, "R6", "max short index", ea, 16'h01FE);

        // R7 wrap past FFFFh
        prog[9'h102] = 8'hFF; prog[9'h103] = 8'hF0;
        run(4'd6, 8'h20, 8'h00, 1'b0, 16'hC102, "R7");
        chk(ea == 16'h0010, "R7", "16-bit wrap", ea, 16'h0010);

        // R10 pointer at FFh wraps to 00h
        prog[9'h104] = 8'hFF; zp[8'hFF] = 8'h12; zp[8'h00] = 8'h34;
        run(4'd8, 8'h00, 8'h00, 1'b0, 16'hC104, "R10");
        chk(ea == 16'h1234, "R10", "page-zero pointer wrap", ea, 16'h1234);

        // R2 unused code
        run(4'hB, 8'h5A, 8'h00, 1'b0, 16'hC105, "R2");

        // R12 start in mid-operation and during DONE
        begin
            logic [15:0] exp_ea;
            int dones;
            exp_ea = ref_ea(4'd8, 8'h00, 16'hC00D);
            @(negedge clk);
            mode = 4'd8; pc = 16'hC00D; use_y = 1'b0; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            @(posedge clk); @(negedge clk);
            mode = 4'd4; x_reg = 8'hEE; start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            while (!done) begin @(posedge clk); @(negedge clk); end
            chk(ea == exp_ea, "R12", "mid-run start ignored", ea, exp_ea);
            start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            dones = 0;
            for (int k = 0; k < 6; k++) begin
                if (done || mem_rd) dones++;
                @(posedge clk); @(negedge clk);
            end
            chk(dones == 0, "R12", "start in DONE ignored", 16'(dones), 16'd0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule